// File: doc/BRIEF.md
# Relocating Address Guard

This block sits between a processor's address output and memory. It holds two privileged values: a relocation offset, which is the lowest physical address a user program may touch, and a limit, which is the size of that program's legal window. Each request is captured in a stage register. In user mode the captured logical address is compared with the limit. A legal address is shifted up by the relocation offset and forwarded to memory. An illegal one raises a protection fault and is never forwarded.

Kernel-mode requests skip both the compare and the add, so the operating system can reach all of memory. The two values are loaded through a small configuration port. That port only accepts writes marked as kernel mode. A user-mode write is dropped and reported on a one-cycle privilege-error pulse.

The physical address is one bit wider than the logical address, so the sum of offset and address never wraps.

Top module: `reloc_guard`

## Requirements
- R1: After reset, both the relocation offset and the limit are zero, and mem_valid, fault and priv_err are low. As a result, any user request made before configuration faults.
- R2: A user-mode request (req_kernel=0) whose address is strictly less than the limit produces, in the cycle after the edge that captured it, mem_valid=1, fault=0 and mem_addr = req_addr + relocation offset.
- R3: A user-mode request whose address is equal to or greater than the limit produces, one cycle after capture, fault=1, mem_valid=0 and mem_addr=0.
- R4: A kernel-mode request (req_kernel=1) produces, one cycle after capture, mem_valid=1, fault=0 and mem_addr equal to req_addr zero-extended. This holds for any limit and offset.
- R5: A configuration write with cfg_kernel=1 loads cfg_wdata into the relocation offset when cfg_sel=0, and into the limit when cfg_sel=1. The new value applies to requests seen at the outputs from the next cycle on.
- R6: A configuration write with cfg_kernel=0 leaves both values unchanged. It raises priv_err for exactly the one cycle after the write edge.
- R7: In a cycle after an edge with req_valid=0, mem_valid and fault are both low.
- R8: The physical address is ADDR_W+1 bits wide and carries the full sum. An offset plus address above 2^ADDR_W-1 appears without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kernel | input | 1 | Privilege of the configuration writer (1 = kernel) |
| cfg_sel | input | 1 | Target value: 0 relocation offset, 1 limit |
| cfg_wdata | input | ADDR_W | Value to load |
| req_valid | input | 1 | Address request present |
| req_kernel | input | 1 | Privilege of the request (1 = kernel) |
| req_addr | input | ADDR_W | Logical address |
| mem_valid | output | 1 | Forwarded access to memory |
| mem_addr | output | ADDR_W+1 | Physical address (0 when not forwarded) |
| fault | output | 1 | Protection fault for the captured request |
| priv_err | output | 1 | One-cycle pulse after a rejected configuration write |

## Verification
The bench sweeps every logical address of a 6-bit configuration under several offset and limit pairs. The pairs include a zero limit, a limit of one and the largest limit.

An off-by-one compare would forward the address equal to the limit, or fault the one just below it. The sweep catches either case. A sum truncated to ADDR_W bits would wrap when the offset is large, and the wide-offset pairs expose it. Kernel requests are checked against a limit of zero, so a design that still applied the check or the offset in kernel mode would fault or shift them. A user-mode write that leaked into the registers would change the translation results that follow it, and a missing or stretched privilege-error pulse is checked cycle by cycle.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;
  typedef enum logic {
    TGT_OFFSET = 1'b0,
    TGT_BOUND  = 1'b1
  } cfg_target_e;
endpackage

// File: rtl/reloc_guard_regs.sv
module reloc_guard_regs
  import reloc_guard_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kernel,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] offset_o,
  output logic [ADDR_W-1:0] bound_o,
  output logic              priv_err_o
);
  cfg_target_e       tgt;
  logic              wr_ok;
  logic              en_offset, en_bound;
  logic [ADDR_W-1:0] offset_q, bound_q;
  logic              err_q, err_d;

  // next-state
  always_comb begin
    tgt       = cfg_target_e'(cfg_sel);
    wr_ok     = cfg_we & cfg_kernel;
    en_offset = wr_ok & (tgt == TGT_OFFSET);
    en_bound  = wr_ok & (tgt == TGT_BOUND);
    err_d     = cfg_we & ~cfg_kernel;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      bound_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      if (en_offset) offset_q <= cfg_wdata;
      if (en_bound)  bound_q  <= cfg_wdata;
      err_q <= err_d;
    end
  end

  assign offset_o   = offset_q;
  assign bound_o    = bound_q;
  assign priv_err_o = err_q;
endmodule

// File: rtl/reloc_guard_xlate.sv
module reloc_guard_xlate #(
  parameter int ADDR_W = 16,
  localparam int PA_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_kernel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] bound_i,
  output logic              mem_valid_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic              fault_o
);
  logic              v_q, k_q;
  logic [ADDR_W-1:0] a_q;
  logic              in_range;
  logic [PA_W-1:0]   sum;

  // request stage registers; address and mode load only with a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      k_q <= 1'b0;
      a_q <= '0;
    end else begin
      v_q <= req_valid;
      if (req_valid) begin
        k_q <= req_kernel;
        a_q <= req_addr;
      end
    end
  end

  // compare and add
  always_comb begin
    in_range = (a_q < bound_i);
    sum      = {1'b0, a_q} + {1'b0, offset_i};
    fault_o     = v_q & ~k_q & ~in_range;
    mem_valid_o = v_q & (k_q | in_range);
    if (!mem_valid_o)  mem_addr_o = '0;
    else if (k_q)      mem_addr_o = {1'b0, a_q};
    else               mem_addr_o = sum;
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard #(
  parameter int ADDR_W = 16,
  localparam int PA_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kernel,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_kernel,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_valid,
  output logic [PA_W-1:0]   mem_addr,
  output logic              fault,
  output logic              priv_err
);
  logic [ADDR_W-1:0] offset_w, bound_w;

  reloc_guard_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_kernel (cfg_kernel),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .offset_o   (offset_w),
    .bound_o    (bound_w),
    .priv_err_o (priv_err)
  );

  reloc_guard_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kernel  (req_kernel),
    .req_addr    (req_addr),
    .offset_i    (offset_w),
    .bound_i     (bound_w),
    .mem_valid_o (mem_valid),
    .mem_addr_o  (mem_addr),
    .fault_o     (fault)
  );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int ADDR_W = 16,
  localparam int PA_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_kernel,
  input logic              req_valid,
  input logic              req_kernel,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] offset_w,
  input logic [ADDR_W-1:0] bound_w,
  input logic              mem_valid,
  input logic [PA_W-1:0]   mem_addr,
  input logic              fault,
  input logic              priv_err
);
  assert_fault_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && mem_valid));

  assert_user_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel) |=> (mem_valid == ($past(req_addr) < bound_w)));

  assert_user_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kernel) |=> (!mem_valid ||
      mem_addr == ({1'b0, $past(req_addr)} + {1'b0, offset_w})));

  assert_kernel_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kernel) |=> (mem_valid && !fault &&
      mem_addr == {1'b0, $past(req_addr)}));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_valid && !fault));

  assert_priv_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_kernel) |=> priv_err);

  assert_priv_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_kernel) |=> !priv_err);

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_kernel) |=> ($stable(offset_w) && $stable(bound_w)));
endmodule

bind reloc_guard reloc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_kernel (cfg_kernel),
  .req_valid  (req_valid),
  .req_kernel (req_kernel),
  .req_addr   (req_addr),
  .offset_w   (offset_w),
  .bound_w    (bound_w),
  .mem_valid  (mem_valid),
  .mem_addr   (mem_addr),
  .fault      (fault),
  .priv_err   (priv_err)
);

// File: tb/reloc_guard_tb.sv
module reloc_guard_tb;
  localparam int AW = 6;
  localparam int PW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_kernel = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0, req_kernel = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          mem_valid, fault, priv_err;
  logic [PW-1:0] mem_addr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  reloc_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kernel(cfg_kernel), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_kernel(req_kernel), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .fault(fault), .priv_err(priv_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic kern, input logic sel, input logic [AW-1:0] val);
    cfg_we = 1'b1; cfg_kernel = kern; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    check(kern ? "R5 priv_err after kernel write" : "R6 priv_err pulse", priv_err, !kern);
    @(negedge clk);
    check("R6 priv_err one cycle only", priv_err, 0);
  endtask

  task automatic user_req(input logic [AW-1:0] a, input logic [AW-1:0] rel, input logic [AW-1:0] lim,
                          input string tag);
    logic ok;
    logic [PW-1:0] exp_pa;
    req_valid = 1'b1; req_kernel = 1'b0; req_addr = a;
    @(negedge clk);
    ok = (a < lim);
    exp_pa = ok ? ({1'b0, a} + {1'b0, rel}) : '0;
    check({tag, ok ? " R2 mem_valid" : " R3 mem_valid"}, mem_valid, ok);
    check({tag, ok ? " R2 fault" : " R3 fault"}, fault, !ok);
    check({tag, ok ? " R8 mem_addr" : " R3 mem_addr"}, mem_addr, exp_pa);
  endtask

  task automatic kern_req(input logic [AW-1:0] a);
    req_valid = 1'b1; req_kernel = 1'b1; req_addr = a;
    @(negedge clk);
    check("R4 kernel mem_valid", mem_valid, 1);
    check("R4 kernel fault", fault, 0);
    check("R4 kernel mem_addr", mem_addr, {1'b0, a});
  endtask

  task automatic idle_chk;
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 idle mem_valid", mem_valid, 0);
    check("R7 idle fault", fault, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] rels [6];
    logic [AW-1:0] lims [6];
    rels = '{6'd0, 6'd5, 6'd30, 6'd63, 6'd10, 6'd1};
    lims = '{6'd0, 6'd20, 6'd63, 6'd63, 6'd1, 6'd40};

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mem_valid", mem_valid, 0);
    check("R1 fault", fault, 0);
    check("R1 priv_err", priv_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    user_req(6'd0, 6'd0, 6'd0, "R1 zero limit");
    idle_chk();

    // R4 kernel passes with limit zero
    kern_req(6'd0);
    kern_req(6'd63);
    kern_req(6'd33);
    idle_chk();

    for (int p = 0; p < 6; p++) begin
      cfg_write(1'b1, 1'b0, rels[p]);  // R5 offset load
      cfg_write(1'b1, 1'b1, lims[p]);  // R5 limit load
      for (int a = 0; a < (1 << AW); a++)
        user_req(a[AW-1:0], rels[p], lims[p], "sweep");
      idle_chk();
    end

    // R6 user writes ignored: offset 63, limit 40 must remain
    cfg_write(1'b1, 1'b0, 6'd63);
    cfg_write(1'b0, 1'b0, 6'd2);
    cfg_write(1'b0, 1'b1, 6'd5);
    user_req(6'd39, 6'd63, 6'd40, "R6 after rejected writes");
    user_req(6'd40, 6'd63, 6'd40, "R6 after rejected writes");
    user_req(6'd10, 6'd63, 6'd40, "R6 after rejected writes");

    // mixed kernel/user back to back
    kern_req(6'd50);
    user_req(6'd50, 6'd63, 6'd40, "R3 after kernel");
    kern_req(6'd7);
    idle_chk();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule